// File: doc/BRIEF.md
# Cascadable Latched Serial-to-Parallel Driver

This block receives a bit stream on a serial data pin, clocked by a slow shift strobe, and collects the last eight bits in a shift chain. A separate storage strobe copies the chain into a holding register in one step. The holding register drives eight low-side channel-on outputs. An active-low output enable can blank all channels at once without touching any register, so it can be used for global PWM dimming. The last chain stage is re-timed on the falling shift strobe and sent out on a cascade pin. Several blocks can therefore share the strobes and form one longer chain, with no race at the shared rising edge.

Both strobes and the serial data are slow external signals. They are brought into one fast system clock through two-flop synchronisers, and edges are found by comparing each synchronised sample with the one before it. The data is synchronised with the same depth as the strobes, so a strobe edge always sees the data that stood beside it. An active-low clear empties the chain, the holding register and the cascade pin. An over-temperature latch is set by a "hot" comparator input and is released only by a "cooled" comparator input. While it is set, all channels are forced off.

Top module: `serial_latch_driver`

## Requirements
- R1: At each detected rising edge of `shift_clk`, the value of `ser_in` becomes stage 0 of the chain and every stage k moves to stage k+1. The bit in stage 7 is dropped.
- R2: At each detected rising edge of `store_clk`, all eight stages are copied into the holding register. The channels change on the third system clock edge after `store_clk` rises and at no other time. When both strobes rise in the same cycle, the holding register takes the contents before the shift.
- R3: While `clear_n` is low, the chain, the holding register and `ser_out` are zero, and strobe edges have no effect. At reset all outputs are zero.
- R4: While `out_en_n` is high, `chan_on` is all zero. The holding register is kept, and its value returns on `chan_on` in the same cycle that `out_en_n` goes low.
- R5: At each detected falling edge of `shift_clk`, `ser_out` takes the value of stage 7. A bit entered at one rising edge therefore appears 7.5 strobe periods later, just after the eighth falling edge.
- R6: While `temp_hot` is high, `chan_on` is all zero in the same cycle. After that, a shutdown latch keeps the channels off until `temp_cooled` is sampled high. `clear_n` does not release the latch.
- R7: When `temp_hot` and `temp_cooled` are high together, the latch sets. The hot input wins.
- R8: Bit i of the holding register drives `chan_on[i]`. The first of eight shifted bits ends on `chan_on[7]` and the last on `chan_on[0]`.
- R9: Two blocks that share both strobes, with the first block's `ser_out` wired to the second block's `ser_in`, take 16 bits in order. After 16 shifts and a store, the second block holds the first eight bits and the first block holds the last eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than either strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data input |
| shift_clk | input | 1 | Shift strobe; each phase lasts at least two system clocks |
| store_clk | input | 1 | Storage strobe; each phase lasts at least two system clocks |
| clear_n | input | 1 | Active-low clear of the chain, holding register and cascade output |
| out_en_n | input | 1 | Active-low output enable, gates the channels combinationally |
| temp_hot | input | 1 | Over-temperature comparator (trip threshold crossed) |
| temp_cooled | input | 1 | Cool-down comparator (release threshold crossed) |
| chan_on | output | 8 | Channel sink enables, 1 = sinking |
| ser_out | output | 1 | Cascade serial output, re-timed on the falling shift strobe |

## Verification
Two collisions matter most. The first is a shift and a store that land in the same system cycle. The bench raises both strobes at the same instant, and it is judged right only if the holding register takes the chain as it was before that shift. The second is the hot and cooled comparators both high at once. That is provoked from a released latch, and it must leave the channels off. A behavioural model with a bit queue follows both cases cycle by cycle, and directed checks confirm the expected constants.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned SLD_CHANNELS = 8;
  localparam int unsigned SLD_SYNC_DEPTH = 2;
  // synchronised input vector layout
  localparam int unsigned SLD_IX_DATA = 0;
  localparam int unsigned SLD_IX_SHIFT = 1;
  localparam int unsigned SLD_IX_STORE = 2;
  localparam int unsigned SLD_IX_CLEARN = 3;
  localparam int unsigned SLD_SYNC_W = 4;

  typedef struct packed {
    logic rise;
    logic fall;
  } sld_edge_t;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int unsigned W = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0][W-1:0] pipe_q;
  logic [DEPTH-1:0][W-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = async_in;
    for (int unsigned i = 1; i < DEPTH; i++) begin
      pipe_d[i] = pipe_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign sync_out = pipe_q[LAST];
endmodule

// File: rtl/sld_edge.sv
module sld_edge
  import sld_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  output sld_edge_t ev
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= lvl;
    end
  end

  always_comb begin
    ev.rise = lvl & ~prev_q;
    ev.fall = ~lvl & prev_q;
  end
endmodule

// File: rtl/sld_shift_chain.sv
module sld_shift_chain #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic         fall,
  input  logic         din,
  output logic [N-1:0] stages,
  output logic         sout
);
  localparam int unsigned TOP = N - 1;

  logic [N-1:0] stg_q, stg_d;
  logic         sout_q, sout_d;
  logic         stg_en, sout_en;

  always_comb begin
    stg_en  = clr | adv;
    sout_en = clr | fall;
    if (clr) begin
      stg_d  = '0;
      sout_d = 1'b0;
    end else begin
      stg_d  = {stg_q[TOP-1:0], din};
      sout_d = stg_q[TOP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else if (stg_en) begin
      stg_q <= stg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sout_q <= 1'b0;
    end else if (sout_en) begin
      sout_q <= sout_d;
    end
  end

  assign stages = stg_q;
  assign sout   = sout_q;

  // R1: shift moves every stage up and loads din
  a_r1_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (stg_q == {$past(stg_q[TOP-1:0]), $past(din)}));
  // R3: clear empties chain and cascade output
  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stg_q == '0 && sout_q == 1'b0));
  // R5: falling strobe publishes the top stage
  a_r5_sout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !clr) |=> (sout_q == $past(stg_q[TOP])));
  // R5: cascade output only moves on a falling strobe or clear
  a_r5_sout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !clr) |=> $stable(sout_q));
endmodule

// File: rtl/sld_hold_reg.sv
module sld_hold_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [N-1:0] src,
  output logic [N-1:0] held
);
  logic [N-1:0] held_q, held_d;
  logic         held_en;

  always_comb begin
    held_en = clr | load;
    held_d  = clr ? '0 : src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  assign held = held_q;

  // R2: a store copies the chain as it stood before the edge
  a_r2_store_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (held_q == $past(src)));
  // R2: without a store the holding register does not move
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> $stable(held_q));
  // R3: clear empties the holding register
  a_r3_hold_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (held_q == '0));
endmodule

// File: rtl/sld_thermal_guard.sv
module sld_thermal_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  input  logic cooled,
  output logic shut
);
  logic shut_q, shut_d;

  always_comb begin
    if (hot) begin
      shut_d = 1'b1;
    end else if (cooled) begin
      shut_d = 1'b0;
    end else begin
      shut_d = shut_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q <= 1'b0;
    end else begin
      shut_q <= shut_d;
    end
  end

  assign shut = shut_q;

  // R7: hot input sets the latch even with cooled high
  a_r7_hot_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hot |=> shut_q);
  // R6: latch holds until cooled is seen
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && !cooled) |=> shut_q);
  // R6: release only through cooled
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cooled && !hot) |=> !shut_q);
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
  import sld_pkg::*;
#(
  parameter int unsigned CHANNELS = SLD_CHANNELS,
  parameter int unsigned SYNC_DEPTH = SLD_SYNC_DEPTH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_in,
  input  logic                shift_clk,
  input  logic                store_clk,
  input  logic                clear_n,
  input  logic                out_en_n,
  input  logic                temp_hot,
  input  logic                temp_cooled,
  output logic [CHANNELS-1:0] chan_on,
  output logic                ser_out
);
  logic [SLD_SYNC_W-1:0] raw_vec, syn_vec;
  sld_edge_t             shift_ev, store_ev;
  logic                  clr;
  logic [CHANNELS-1:0]   stages, held;
  logic                  shut, blank;

  assign raw_vec[SLD_IX_DATA]   = ser_in;
  assign raw_vec[SLD_IX_SHIFT]  = shift_clk;
  assign raw_vec[SLD_IX_STORE]  = store_clk;
  assign raw_vec[SLD_IX_CLEARN] = clear_n;

  sld_sync #(.W(SLD_SYNC_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_vec), .sync_out(syn_vec)
  );

  sld_edge u_shift_edge (
    .clk(clk), .rst_n(rst_n), .lvl(syn_vec[SLD_IX_SHIFT]), .ev(shift_ev)
  );

  sld_edge u_store_edge (
    .clk(clk), .rst_n(rst_n), .lvl(syn_vec[SLD_IX_STORE]), .ev(store_ev)
  );

  assign clr = ~syn_vec[SLD_IX_CLEARN];

  sld_shift_chain #(.N(CHANNELS)) u_chain (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(shift_ev.rise),
    .fall(shift_ev.fall), .din(syn_vec[SLD_IX_DATA]),
    .stages(stages), .sout(ser_out)
  );

  sld_hold_reg #(.N(CHANNELS)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(store_ev.rise),
    .src(stages), .held(held)
  );

  sld_thermal_guard u_thermal (
    .clk(clk), .rst_n(rst_n), .hot(temp_hot), .cooled(temp_cooled),
    .shut(shut)
  );

  always_comb begin
    blank   = out_en_n | temp_hot | shut;
    chan_on = blank ? '0 : held;
  end

  // R6: a latched shutdown keeps every channel dark
  a_r6_shut_dark: assert property (@(posedge clk) disable iff (!rst_n)
    shut |-> (chan_on == '0));
  // R4: enable high blanks the channels in the same cycle
  a_r4_enable_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (chan_on == '0));
endmodule

// File: tb/serial_latch_driver_test.sv
module serial_latch_driver_test;
  logic clk = 1'b0;
  logic rst_n, ser_in, shift_clk, store_clk, clear_n, out_en_n;
  logic temp_hot, temp_cooled;
  logic [7:0] chan_on, chan2;
  logic ser_out, ser_out2;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_latch_driver uut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
    .store_clk(store_clk), .clear_n(clear_n), .out_en_n(out_en_n),
    .temp_hot(temp_hot), .temp_cooled(temp_cooled),
    .chan_on(chan_on), .ser_out(ser_out)
  );

  serial_latch_driver uut2 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_out), .shift_clk(shift_clk),
    .store_clk(store_clk), .clear_n(clear_n), .out_en_n(out_en_n),
    .temp_hot(1'b0), .temp_cooled(1'b0),
    .chan_on(chan2), .ser_out(ser_out2)
  );

  // behavioural reference: delayed input samples and a bit queue
  logic [3:0] m_s1, m_s2;            // {clear_n, store, shift, data}
  logic m_sck_prev, m_stk_prev, m_hot, m_sout;
  logic [7:0] m_held;
  bit   m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_sck_prev = 0; m_stk_prev = 0;
      m_hot = 0; m_sout = 0; m_held = '0;
      m_q = {0,0,0,0,0,0,0,0};
    end else begin
      if (!m_s2[3]) begin
        m_q = {0,0,0,0,0,0,0,0};
        m_held = '0;
        m_sout = 0;
      end else begin
        if (m_s2[2] && !m_stk_prev)
          for (int i = 0; i < 8; i++) m_held[i] = m_q[i];
        if (m_s2[1] && !m_sck_prev) begin
          m_q.push_front(m_s2[0]);
          void'(m_q.pop_back());
        end
        if (!m_s2[1] && m_sck_prev) m_sout = m_q[7];
      end
      if (temp_hot) m_hot = 1;
      else if (temp_cooled) m_hot = 0;
      m_sck_prev = m_s2[1];
      m_stk_prev = m_s2[2];
      m_s2 = m_s1;
      m_s1 = {clear_n, store_clk, shift_clk, ser_in};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] exp_c;
      exp_c = (out_en_n || temp_hot || m_hot) ? 8'h00 : m_held;
      checks++;
      if (chan_on !== exp_c) begin
        errors++;
        $display("FAIL R2 model chan_on actual %h expected %h at %0t", chan_on, exp_c, $time);
      end
      checks++;
      if (ser_out !== m_sout) begin
        errors++;
        $display("FAIL R5 model ser_out actual %b expected %b at %0t", ser_out, m_sout, $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b; tick(2);
    shift_clk = 1; tick(3);
    shift_clk = 0; tick(3);
  endtask

  task automatic shift_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic store();
    store_clk = 1; tick(3);
    store_clk = 0; tick(3);
  endtask

  initial begin
    rst_n = 0; ser_in = 0; shift_clk = 0; store_clk = 0; clear_n = 1;
    out_en_n = 0; temp_hot = 0; temp_cooled = 0;
    tick(3);
    check("R3 reset chan_on", chan_on, 8'h00);
    check("R3 reset ser_out", {7'd0, ser_out}, 8'h00);
    rst_n = 1; tick(4);

    // R1 R8: load a pattern; channels hold until the store
    shift_byte(8'hB2);
    check("R2 no change before store", chan_on, 8'h00);
    check("R5 first bit out after 8 falls", {7'd0, ser_out}, 8'h01);
    store_clk = 1; tick(2);
    check("R2 not yet at second edge", chan_on, 8'h00);
    tick(1);
    check("R2 R8 after store", chan_on, 8'hB2);
    store_clk = 0; tick(3);

    // R4: enable gating keeps the register
    out_en_n = 1; #1;
    check("R4 blank same cycle", chan_on, 8'h00);
    tick(5);
    check("R4 blank held", chan_on, 8'h00);
    out_en_n = 0; #1;
    check("R4 restore", chan_on, 8'hB2);
    tick(1);

    // R1: one more bit shifts everything up
    shift_bit(1'b1);
    store();
    check("R1 single shift", chan_on, 8'h65);
    check("R5 ser_out after shift", {7'd0, ser_out}, 8'h00);

    // R2: both strobes in one cycle, store sees pre-shift chain
    ser_in = 0; tick(2);
    shift_clk = 1; store_clk = 1; tick(3);
    shift_clk = 0; store_clk = 0; tick(3);
    check("R2 simultaneous edges", chan_on, 8'h65);
    store();
    check("R1 shifted after collision", chan_on, 8'hCA);

    // R3: clear empties all and ignores strobes
    clear_n = 0; tick(4);
    check("R3 clear chan_on", chan_on, 8'h00);
    shift_bit(1'b1);
    store();
    check("R3 strobes ignored", chan_on, 8'h00);
    check("R3 ser_out cleared", {7'd0, ser_out}, 8'h00);
    clear_n = 1; tick(4);
    store();
    check("R3 chain empty after clear", chan_on, 8'h00);

    // R6: thermal trip and latch
    shift_byte(8'hFF);
    store();
    check("R6 loaded", chan_on, 8'hFF);
    temp_hot = 1; #1;
    check("R6 trip immediate", chan_on, 8'h00);
    tick(2);
    temp_hot = 0; tick(5);
    check("R6 latched off", chan_on, 8'h00);
    clear_n = 0; tick(4); clear_n = 1; tick(4);
    shift_byte(8'h3C);
    store();
    check("R6 clear does not release", chan_on, 8'h00);
    temp_cooled = 1; tick(1);
    temp_cooled = 0; tick(1);
    check("R6 released", chan_on, 8'h3C);
    // R7: both comparators high
    temp_hot = 1; temp_cooled = 1; tick(2);
    temp_hot = 0; temp_cooled = 0; tick(3);
    check("R7 hot wins", chan_on, 8'h00);
    temp_cooled = 1; tick(1); temp_cooled = 0; tick(1);
    check("R7 release after", chan_on, 8'h3C);

    // R9: two chained blocks take 16 bits
    clear_n = 0; tick(4); clear_n = 1; tick(4);
    shift_byte(8'hA5);
    shift_byte(8'h3C);
    store();
    check("R9 near block last byte", chan_on, 8'h3C);
    check("R9 far block first byte", chan2, 8'hA5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule